// File: doc/BRIEF.md
# Program Flow Trace Recorder

This block records where a processor's program flow jumps. It watches an execution-trace strobe. Each time a cycle is marked as a non-sequential change, such as a taken branch or an exception entry, it writes a two-word packet into a circular region of on-chip SRAM. The first word holds the address jumped from and the second holds the address jumped to. Sequential execution is never recorded, so the buffer holds only the points where control flow moved.

The SRAM is split into an even and an odd word bank. A whole packet is stored in one cycle, and the banks stay reachable from a processor data port. A trace write always wins the SRAM. A processor access in that cycle sees its ready signal low, takes no effect, and completes when it is presented again. A small register file holds the write pointer with a sticky wrap flag, the recording enable with a buffer-size code, and a watermark with stop and halt-request controls. A read-only register tells a debug agent where the trace RAM sits in the address map.

Top module: `flow_trace_rec`

## Requirements
- R1: After reset the enable is 0, the pointer and wrap flag are 0, the watermark controls are 0, `halt_req` is 0, and `cpu_ready` is 1.
- R2: A packet is written, and the pointer moves, only in a cycle with `tr_valid`=1, `tr_nonseq`=1 and the enable set. Sequential cycles and cycles while disabled leave the pointer and SRAM unchanged.
- R3: A packet at byte pointer P writes word P/4 as {`tr_src`[31:1], `tr_exc`} and word P/4+1 as {`tr_dst`[31:1], first-flag}, at the clock edge that ends the trace cycle.
- R4: Each packet advances the pointer by 8 bytes. The pointer register (select 0) reads the pointer in bits [PW-1:3], where PW = log2(DEPTH*4), and the wrap flag in bit 2.
- R5: The first-flag is set by a control write that turns the enable from 0 to 1, and it is cleared once a packet has been written.
- R6: The size code c selects a region of 2^(c+4) bytes, aligned to its size, that contains the pointer; c is clamped to PW-4. When a packet would pass the region's end, the pointer returns to the region's start and the wrap flag is set. Only a write to the pointer register clears the wrap flag.
- R7: When a packet moves the pointer onto the watermark and auto-stop is on, the enable clears at that edge and later branches are not recorded.
- R8: When a packet moves the pointer onto the watermark and auto-halt is on, `halt_req` is 1 for exactly the next cycle, whether or not auto-stop is on.
- R9: A processor access in a trace-write cycle sees `cpu_ready`=0 and has no effect. Otherwise a write lands at word `cpu_addr`, and a read returns that word on `cpu_rdata` in the following cycle.
- R10: The base register (select 3) always reads the BASE_ADDR parameter, and writes to it are ignored.
- R11: Register layout: select 1 holds the enable in bit 31 and the size code in bits [3:0]; select 2 holds the watermark in bits [PW-1:3], auto-halt in bit 1 and auto-stop in bit 0. A register write takes precedence over a hardware update of the same register in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tr_valid | input | 1 | Trace interface holds a retired instruction this cycle |
| tr_nonseq | input | 1 | Flow changed non-sequentially this cycle |
| tr_exc | input | 1 | The change is an exception entry |
| tr_src | input | 31 | Address the flow left, bits 31:1 |
| tr_dst | input | 31 | Address the flow went to, bits 31:1 |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 pointer, 1 control, 2 watermark, 3 base |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Contents of the selected register |
| cpu_req | input | 1 | Processor SRAM access request |
| cpu_we | input | 1 | Processor access is a write |
| cpu_addr | input | log2(DEPTH) | Processor word address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Processor read data, one cycle after acceptance |
| cpu_ready | output | 1 | Low when a processor access is stalled by a trace write |
| halt_req | output | 1 | One-cycle halt request on a watermark hit |

## Verification
The bench uses the default of 64 words, a 256-byte trace RAM. At size code 4 the region spans the whole RAM, and codes above 4 clamp to it. At code 0 the region holds two packets, so a wrap, an overwrite of the oldest packet and a return to the region's base take only a few branches. The small pointer also puts the watermark, the top-of-memory wrap and every bank row within a run of a few hundred cycles.

// File: rtl/ftr_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the flow trace recorder.
// Assumes: register selects are two bits wide and the size code is four bits.
package ftr_pkg;

    typedef enum logic [1:0] {
        SEL_PTR  = 2'd0,
        SEL_CTL  = 2'd1,
        SEL_FLOW = 2'd2,
        SEL_BASE = 2'd3
    } ftr_sel_e;

    localparam int CODE_W = 4;

    // Packs a halfword-aligned address with a flag in bit 0.
    function automatic logic [31:0] pack_word(input logic [30:0] pc, input logic flag);
        return {pc, flag};
    endfunction

endpackage

// File: rtl/ftr_sram_bank.sv
`timescale 1ns/1ps
// One 32-bit bank of the trace RAM: single port with a synchronous write
// and a registered read.
// Assumes: the caller asserts at most one access per cycle. The contents are
// not reset.
module ftr_sram_bank #(
    parameter int ROWS = 32
) (
    input  logic                      clk,
    input  logic                      en,
    input  logic                      we,
    input  logic [$clog2(ROWS)-1:0]   addr,
    input  logic [31:0]               wdata,
    output logic [31:0]               rdata
);
    logic [31:0] mem [ROWS];

    // Write or read the addressed row when enabled.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end
endmodule

// File: rtl/ftr_ptr_unit.sv
`timescale 1ns/1ps
// Write pointer for the trace RAM. It counts in packet units (8 bytes),
// wraps inside a region of 2^(code+4) bytes aligned to its size, keeps a
// sticky wrap flag and flags a watermark hit.
// Assumes: IW >= 2, so that the smallest region holds two packets.
module ftr_ptr_unit #(
    parameter int IW = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      adv,
    input  logic                      sw_we,
    input  logic [IW-1:0]             sw_idx,
    input  logic                      sw_wrap,
    input  logic [ftr_pkg::CODE_W-1:0] size_code,
    input  logic [IW-1:0]             wm_idx,
    output logic [IW-1:0]             idx_q,
    output logic                      wrap_q,
    output logic                      wm_hit
);
    localparam logic [ftr_pkg::CODE_W-1:0] MAX_CODE = ftr_pkg::CODE_W'(IW - 1);

    logic [ftr_pkg::CODE_W-1:0] eff_code;
    logic [IW-1:0]              pmask;
    logic [IW-1:0]              step;
    logic [IW-1:0]              nxt;
    logic                       wraps;

    // Clamp the size code and form the in-region packet mask.
    always_comb begin
        eff_code = (size_code > MAX_CODE) ? MAX_CODE : size_code;
        pmask    = (IW'(1) << (eff_code + 1'b1)) - IW'(1);
    end

    // Next pointer inside the region, the wrap condition and the watermark hit.
    always_comb begin
        step   = idx_q + IW'(1);
        nxt    = (idx_q & ~pmask) | (step & pmask);
        wraps  = ((step & pmask) == '0);
        wm_hit = adv && !sw_we && (nxt == wm_idx);
    end

    // Pointer and wrap flag: a register write wins over an advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            wrap_q <= 1'b0;
        end else if (sw_we) begin
            idx_q  <= sw_idx;
            wrap_q <= sw_wrap;
        end else if (adv) begin
            idx_q  <= nxt;
            wrap_q <= wrap_q | wraps;
        end
    end

    // R6: the wrap flag falls only after a register write.
    p_wrap_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wrap_q) |-> $past(sw_we));

endmodule

// File: rtl/flow_trace_rec.sv
`timescale 1ns/1ps
// Program flow trace recorder. It stores a two-word packet in a two-bank
// SRAM for each non-sequential program flow change, keeps the write pointer,
// wrap, watermark stop and halt request, and gives trace writes priority
// over processor accesses.
// Assumes: DEPTH is a power of two >= 8 words, and the trace interface
// presents at most one flow change per cycle.
module flow_trace_rec #(
    parameter int          DEPTH     = 64,
    parameter logic [31:0] BASE_ADDR = 32'h2000_4000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tr_valid,
    input  logic                       tr_nonseq,
    input  logic                       tr_exc,
    input  logic [31:1]                tr_src,
    input  logic [31:1]                tr_dst,
    input  logic                       cfg_we,
    input  logic [1:0]                 cfg_sel,
    input  logic [31:0]                cfg_wdata,
    output logic [31:0]                cfg_rdata,
    input  logic                       cpu_req,
    input  logic                       cpu_we,
    input  logic [$clog2(DEPTH)-1:0]   cpu_addr,
    input  logic [31:0]                cpu_wdata,
    output logic [31:0]                cpu_rdata,
    output logic                       cpu_ready,
    output logic                       halt_req
);
    import ftr_pkg::*;

    localparam int CAW = $clog2(DEPTH);
    localparam int IW  = CAW - 1;
    localparam int PW  = CAW + 2;

    logic                 en_q, first_q, as_q, ah_q, halt_q, rd_sel_q;
    logic [CODE_W-1:0]    code_q;
    logic [IW-1:0]        wm_q;
    logic [IW-1:0]        ptr_idx;
    logic                 ptr_wrap;
    logic                 wm_hit;
    logic                 trace_wr, cpu_go;
    logic                 ptr_we, ctl_we, flow_we;
    logic [1:0][31:0]     pkt;
    logic [1:0][31:0]     bank_rd;
    logic                 unused_wbits;

    assign unused_wbits = ^cfg_wdata[30:PW];

    // Decode the register write strobes.
    always_comb begin
        ptr_we  = cfg_we && (cfg_sel == SEL_PTR);
        ctl_we  = cfg_we && (cfg_sel == SEL_CTL);
        flow_we = cfg_we && (cfg_sel == SEL_FLOW);
    end

    // Recognise a trace write and arbitrate the processor port against it.
    always_comb begin
        trace_wr  = tr_valid && tr_nonseq && en_q;
        cpu_go    = cpu_req && !trace_wr;
        cpu_ready = !(cpu_req && trace_wr);
        pkt[0]    = pack_word(tr_src, tr_exc);
        pkt[1]    = pack_word(tr_dst, first_q);
    end

    ftr_ptr_unit #(.IW(IW)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (trace_wr),
        .sw_we     (ptr_we),
        .sw_idx    (cfg_wdata[PW-1:3]),
        .sw_wrap   (cfg_wdata[2]),
        .size_code (code_q),
        .wm_idx    (wm_q),
        .idx_q     (ptr_idx),
        .wrap_q    (ptr_wrap),
        .wm_hit    (wm_hit)
    );

    // Even bank holds the source word, odd bank the destination word.
    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic          ben, bwe;
        logic [IW-1:0] baddr;
        logic [31:0]   bwd;

        // Steer the bank to the trace packet or to the processor.
        always_comb begin
            ben   = trace_wr || (cpu_go && (cpu_addr[0] == 1'(b)));
            bwe   = trace_wr || (cpu_go && cpu_we && (cpu_addr[0] == 1'(b)));
            baddr = trace_wr ? ptr_idx : cpu_addr[CAW-1:1];
            bwd   = trace_wr ? pkt[b] : cpu_wdata;
        end

        ftr_sram_bank #(.ROWS(DEPTH / 2)) u_bank (
            .clk   (clk),
            .en    (ben),
            .we    (bwe),
            .addr  (baddr),
            .wdata (bwd),
            .rdata (bank_rd[b])
        );
    end

    // Remember which bank an accepted processor read went to.
    always_ff @(posedge clk) begin
        if (!rst_n)                       rd_sel_q <= 1'b0;
        else if (cpu_go && !cpu_we)       rd_sel_q <= cpu_addr[0];
    end

    assign cpu_rdata = bank_rd[rd_sel_q];

    // Control register: enable, size code and first-packet flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            code_q  <= '0;
            first_q <= 1'b0;
        end else begin
            if (trace_wr)          first_q <= 1'b0;
            if (wm_hit && as_q)    en_q    <= 1'b0;
            if (ctl_we) begin
                en_q   <= cfg_wdata[31];
                code_q <= cfg_wdata[CODE_W-1:0];
                if (cfg_wdata[31] && !en_q) first_q <= 1'b1;
            end
        end
    end

    // Watermark register with the stop and halt controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wm_q <= '0;
            as_q <= 1'b0;
            ah_q <= 1'b0;
        end else if (flow_we) begin
            wm_q <= cfg_wdata[PW-1:3];
            as_q <= cfg_wdata[0];
            ah_q <= cfg_wdata[1];
        end
    end

    // One-cycle halt request after a watermark hit.
    always_ff @(posedge clk) begin
        if (!rst_n) halt_q <= 1'b0;
        else        halt_q <= wm_hit && ah_q;
    end

    assign halt_req = halt_q;

    // Register read multiplexer.
    always_comb begin
        case (cfg_sel)
            SEL_PTR:  cfg_rdata = 32'({ptr_idx, ptr_wrap, 2'b00});
            SEL_CTL:  cfg_rdata = {en_q, {(31 - CODE_W){1'b0}}, code_q};
            SEL_FLOW: cfg_rdata = 32'({wm_q, 1'b0, ah_q, as_q});
            default:  cfg_rdata = BASE_ADDR;
        endcase
    end

    // R8: the halt request never lasts two cycles.
    p_halt_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halt_q |=> !halt_q);

    // R7: a watermark hit with auto-stop leaves the enable clear.
    p_stop_at_mark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wm_hit && as_q && !ctl_we |=> !en_q);

    // R2: the pointer moves on its own only while recording is enabled.
    p_move_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr_idx) && !$past(ptr_we) |-> $past(en_q));

    // R5: the first-flag is gone after a packet is written.
    p_first_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trace_wr && !ctl_we |=> !first_q);

endmodule

// File: tb/flow_trace_rec_tb.sv
`timescale 1ns/1ps
module flow_trace_rec_tb;
    localparam int          DEPTH = 64;
    localparam int          PW    = $clog2(DEPTH * 4);
    localparam logic [31:0] BASE  = 32'h2000_4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tr_valid = 0, tr_nonseq = 0, tr_exc = 0;
    logic [31:1] tr_src = '0, tr_dst = '0;
    logic        cfg_we = 0;
    logic [1:0]  cfg_sel = 0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;
    logic        cpu_req = 0, cpu_we = 0;
    logic [5:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0, cpu_rdata;
    logic        cpu_ready, halt_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    flow_trace_rec #(.DEPTH(DEPTH), .BASE_ADDR(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .tr_valid(tr_valid), .tr_nonseq(tr_nonseq),
        .tr_exc(tr_exc), .tr_src(tr_src), .tr_dst(tr_dst), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .halt_req(halt_req)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state
    logic [31:0] m_mem [DEPTH];
    int  m_idx, m_wm, m_code;
    bit  m_wrap, m_en, m_first, m_as, m_ah, m_halt, rd_pend;
    logic [31:0] rd_exp;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_idx = 0; m_wrap = 0; m_en = 0; m_first = 0; m_code = 0;
            m_wm = 0; m_as = 0; m_ah = 0; m_halt = 0; rd_pend = 0;
        end else begin
            bit tw, hit, wrapped, en_old;
            int eff, region, nxt;
            en_old = m_en;
            tw = tr_valid && tr_nonseq && m_en;
            rd_pend = 0;
            if (cpu_req && !tw) begin
                if (cpu_we) m_mem[cpu_addr] = cpu_wdata;
                else begin rd_exp = m_mem[cpu_addr]; rd_pend = 1; end
            end
            eff = (m_code > PW - 4) ? PW - 4 : m_code;
            region = 2 << eff;
            nxt = (m_idx / region) * region + (m_idx + 1) % region;
            wrapped = ((m_idx + 1) % region) == 0;
            hit = tw && !(cfg_we && cfg_sel == 0) && nxt == m_wm;
            if (tw) begin
                m_mem[2 * m_idx]     = {tr_src, tr_exc};
                m_mem[2 * m_idx + 1] = {tr_dst, m_first};
                m_first = 0;
                if (!(cfg_we && cfg_sel == 0)) begin
                    m_idx = nxt;
                    m_wrap = m_wrap | wrapped;
                end
                if (hit && m_as) m_en = 0;
            end
            if (cfg_we) begin
                case (cfg_sel)
                    2'd0: begin m_idx = int'(cfg_wdata[PW-1:3]); m_wrap = cfg_wdata[2]; end
                    2'd1: begin
                        if (cfg_wdata[31] && !en_old) m_first = 1;
                        m_en = cfg_wdata[31]; m_code = int'(cfg_wdata[3:0]);
                    end
                    2'd2: begin m_wm = int'(cfg_wdata[PW-1:3]); m_as = cfg_wdata[0]; m_ah = cfg_wdata[1]; end
                    default: ;
                endcase
            end
            m_halt = hit && m_ah;
        end
    end

    // Cycle-by-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [31:0] exp_cfg;
            case (cfg_sel)
                2'd0: exp_cfg = 32'((m_idx << 3) | (int'(m_wrap) << 2));
                2'd1: exp_cfg = {m_en, 27'd0, 4'(m_code)};
                2'd2: exp_cfg = 32'((m_wm << 3) | (int'(m_ah) << 1) | int'(m_as));
                default: exp_cfg = BASE;
            endcase
            check("R8 halt_req model", {31'd0, halt_req}, {31'd0, m_halt});
            check("R9 cpu_ready model", {31'd0, cpu_ready},
                  {31'd0, !(cpu_req && tr_valid && tr_nonseq && m_en)});
            check("R4/R11 cfg_rdata model", cfg_rdata, exp_cfg);
            if (rd_pend) check("R3/R9 cpu_rdata model", cpu_rdata, rd_exp);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 20000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk); #0.5;
        tr_valid = 0; tr_nonseq = 0; tr_exc = 0;
        cfg_we = 0; cpu_req = 0; cpu_we = 0;
    endtask

    task automatic branch(input logic [31:0] s, input logic [31:0] d, input logic e);
        tick();
        tr_valid = 1; tr_nonseq = 1; tr_exc = e; tr_src = s[31:1]; tr_dst = d[31:1];
    endtask

    task automatic cfg_wr(input logic [1:0] sel, input logic [31:0] v);
        tick();
        cfg_we = 1; cfg_sel = sel; cfg_wdata = v;
    endtask

    task automatic cfg_rd(input logic [1:0] sel, output logic [31:0] v);
        tick();
        cfg_sel = sel; #0.5; v = cfg_rdata;
    endtask

    task automatic cpu_wr(input logic [5:0] a, input logic [31:0] v);
        tick();
        cpu_req = 1; cpu_we = 1; cpu_addr = a; cpu_wdata = v;
    endtask

    task automatic cpu_rd(input logic [5:0] a, output logic [31:0] v);
        tick();
        cpu_req = 1; cpu_we = 0; cpu_addr = a;
        tick();
        v = cpu_rdata;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        #0.5 rst_n = 1;

        // R1: reset state
        cfg_rd(0, v); check("R1 pointer after reset", v, 32'h0);
        cfg_rd(1, v); check("R1 control after reset", v, 32'h0);
        cfg_rd(2, v); check("R1 watermark after reset", v, 32'h0);
        check("R1 halt_req after reset", {31'd0, halt_req}, 32'h0);
        check("R1 cpu_ready after reset", {31'd0, cpu_ready}, 32'h1);

        // R2: branch while disabled is ignored
        branch(32'h1000, 32'h2000, 0);
        cfg_rd(0, v); check("R2 no packet while disabled", v, 32'h0);

        // R3/R5: packets with first-flag, sequential step ignored
        cfg_wr(1, 32'h8000_0004);
        branch(32'h100, 32'h200, 0);
        tick(); tr_valid = 1; tr_nonseq = 0; tr_src = 31'h7FFF_0000;
        cfg_rd(0, v); check("R2 sequential step ignored, R4 +8", v, 32'h8);
        branch(32'h304, 32'h404, 1);
        cfg_rd(0, v); check("R4 pointer after two packets", v, 32'h10);
        cpu_rd(0, v); check("R3 word0 source", v, 32'h100);
        cpu_rd(1, v); check("R5 word1 first-flag set", v, 32'h201);
        cpu_rd(2, v); check("R3 exception flag in word0", v, 32'h305);
        cpu_rd(3, v); check("R5 first-flag clear on second packet", v, 32'h404);

        // R9: processor write loses to a trace write
        cpu_wr(40, 32'h0000_AAAA);
        branch(32'h500, 32'h600, 0);
        cpu_req = 1; cpu_we = 1; cpu_addr = 40; cpu_wdata = 32'h5555;
        #0.5 check("R9 ready low during trace write", {31'd0, cpu_ready}, 32'h0);
        cpu_rd(40, v); check("R9 stalled write has no effect", v, 32'h0000_AAAA);

        // R6: two-packet region wraps, overwrites and sets wrap
        cfg_wr(1, 32'h8000_0000);
        branch(32'h700, 32'h800, 0);
        cfg_rd(0, v); check("R6 wrap to region start", v, 32'h14);
        branch(32'h900, 32'hA00, 0);
        cfg_rd(0, v); check("R6 wrap flag sticky", v, 32'h1C);
        cpu_rd(4, v); check("R6 oldest packet overwritten", v, 32'h900);
        cfg_wr(0, 32'h0);
        cfg_rd(0, v); check("R6 register write clears wrap", v, 32'h0);

        // R7/R8: watermark with auto-stop and auto-halt
        cfg_wr(1, 32'h8000_0004);
        cfg_wr(2, 32'h0000_001B);
        branch(32'h10, 32'h20, 0);
        branch(32'h30, 32'h40, 0);
        branch(32'h50, 32'h60, 0);
        tick(); check("R8 halt_req pulse after hit", {31'd0, halt_req}, 32'h1);
        tick(); check("R8 halt_req only one cycle", {31'd0, halt_req}, 32'h0);
        cfg_rd(1, v); check("R7 auto-stop cleared enable", v, 32'h0000_0004);
        branch(32'h70, 32'h80, 0);
        cfg_rd(0, v); check("R7 no packet after stop", v, 32'h18);

        // R8 without auto-stop; R5 first-flag after re-enable
        cfg_wr(2, 32'h0000_0022);
        cfg_wr(1, 32'h8000_0004);
        branch(32'hB00, 32'hC00, 0);
        tick(); check("R8 halt without auto-stop", {31'd0, halt_req}, 32'h1);
        cfg_rd(1, v); check("R8 enable kept when auto-stop off", v, 32'h8000_0004);
        cpu_rd(7, v); check("R5 first-flag after re-enable", v, 32'hC01);

        // R6: size code clamped to whole memory, wrap at top
        cfg_wr(1, 32'h8000_000F);
        cfg_wr(0, 32'h0000_00F8);
        branch(32'hD00, 32'hE00, 0);
        cfg_rd(0, v); check("R6 clamped region wraps at top", v, 32'h4);
        cpu_rd(62, v); check("R3 packet at top row", v, 32'hD00);

        // R10: base register read-only
        cfg_wr(3, 32'hFFFF_FFFF);
        cfg_rd(3, v); check("R10 base register", v, BASE);

        // R9/R11: plain processor access and control readback
        cpu_wr(33, 32'h1234_5678);
        cpu_rd(33, v); check("R9 processor write and read", v, 32'h1234_5678);
        cfg_rd(2, v); check("R11 watermark layout", v, 32'h0000_0022);

        tick(); tick();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule